// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one read or write request into the sequence of column addresses that a synchronous DRAM burst walks through. A controller pulses a start strobe together with the first column and the mode fields it has programmed: a length code, an ordering bit, a write-single bit and the request direction. From the next clock on, the block presents one column per cycle with a valid flag, and marks the final column with a last flag.

Two beat orderings are supported. Sequential order counts upward inside the aligned block that the burst length defines. Interleaved order XORs the beat number into the low column bits. A full-page length walks every column of the row with wrap-around. A stop strobe ends the burst on the next clock. A fresh start strobe during a burst abandons it and begins again from the new column. A separate combinational flag reports mode words whose must-be-zero bits are set.

Top module: `sdram_burst_colgen`

## Requirements
- R1: A start strobe with a legal length code makes `valid_o` high on the next clock, and that first beat presents `start_col_i` unchanged, in either ordering.
- R2: Length codes 3'b000, 3'b001, 3'b010, 3'b011 and 3'b111 give bursts of 1, 2, 4, 8 and 2**COL_W beats (256 by default).
- R3: Length codes 3'b100, 3'b101 and 3'b110 are reserved. A start strobe carrying one begins no burst: an idle generator stays idle, and a running burst carries on with its next column.
- R4: With `order_i` = 0 (sequential), beat n presents the start column with its low log2(BL) bits replaced by (start + n) mod BL. The upper bits stay as given.
- R5: With `order_i` = 1 (interleaved), beat n presents the start column with its low log2(BL) bits XORed with n. A full-page burst ignores this bit and runs sequentially.
- R6: A full-page burst steps through every column, wrapping from the top column to column 0, and flags last on beat 2**COL_W.
- R7: When `is_write_i` and `wr_single_i` are both 1 at start, the burst is exactly one beat, whatever the length code. With `wr_single_i` = 0, or for reads, the coded length applies.
- R8: `stop_i` high without a legal start ends the burst: `valid_o` is low on the next clock.
- R9: A legal start during a burst abandons it, and the next clock shows beat 0 of the new burst. When start and stop arrive in the same cycle, the start wins.
- R10: `last_o` is high only together with the final beat's column. `valid_o` is low on the following clock unless a legal start was given in that cycle.
- R11: `mode_bad_o` is high in the same cycle whenever any bit of `rsvd_bits_i` is 1, and low when all of them are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst (or restart one) |
| start_col_i | input | COL_W | First column of the burst |
| is_write_i | input | 1 | Request is a write |
| len_code_i | input | 3 | Burst-length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| wr_single_i | input | 1 | Writes use single-location access |
| stop_i | input | 1 | End the current burst |
| rsvd_bits_i | input | RSVD_W | Mode-word bits that must be zero |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Current beat is the final one |
| mode_bad_o | output | 1 | Mode word has a must-be-zero bit set |

## Verification
Two things can fall in the same cycle. The final beat can coincide with a new start, and a stop can coincide with a start. The bench presents a start at the very clock that shows `last_o`, and expects beat 0 of the new burst on the next clock with no gap. It also raises start and stop together in the middle of an 8-beat burst, and judges that the new burst's first column appears and then runs its full length, so the stop has been overridden.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

   localparam logic [2:0] LEN_1    = 3'b000;
   localparam logic [2:0] LEN_2    = 3'b001;
   localparam logic [2:0] LEN_4    = 3'b010;
   localparam logic [2:0] LEN_8    = 3'b011;
   localparam logic [2:0] LEN_PAGE = 3'b111;

   typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} beat_order_e;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
   import sdram_colgen_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [2:0]       code_i,
   input  logic             force_one_i,
   output logic [COL_W-1:0] mask_o,
   output logic             legal_o,
   output logic             page_o
);

   always_comb begin
      mask_o  = '0;
      legal_o = 1'b1;
      page_o  = 1'b0;
      unique case (code_i)
         LEN_1:    mask_o = '0;
         LEN_2:    mask_o = COL_W'(1);
         LEN_4:    mask_o = COL_W'(3);
         LEN_8:    mask_o = COL_W'(7);
         LEN_PAGE: begin
            mask_o = '1;
            page_o = 1'b1;
         end
         default:  legal_o = 1'b0;
      endcase
      if (force_one_i) begin
         mask_o = '0;
         page_o = 1'b0;
      end
   end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             xor_i,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] cnt_o,
   output logic [COL_W-1:0] mask_o,
   output logic             xor_o,
   output logic             valid_o,
   output logic             final_o
);

   assign final_o = valid_o && (cnt_o == mask_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o  <= '0;
         cnt_o   <= '0;
         mask_o  <= '0;
         xor_o   <= 1'b0;
         valid_o <= 1'b0;
      end else if (load_i) begin
         base_o  <= col_i;
         cnt_o   <= '0;
         mask_o  <= mask_i;
         xor_o   <= xor_i;
         valid_o <= 1'b1;
      end else if (stop_i || final_o) begin
         valid_o <= 1'b0;
      end else if (valid_o) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             xor_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] sum_w;
   logic [COL_W-1:0] mix_w;

   assign sum_w = base_i + cnt_i;
   assign mix_w = base_i ^ cnt_i;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      assign col_o[b] = mask_i[b] ? (xor_i ? mix_w[b] : sum_w[b]) : base_i[b];
   end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import sdram_colgen_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter int RSVD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COL_W-1:0]  start_col_i,
   input  logic              is_write_i,
   input  logic [2:0]        len_code_i,
   input  logic              order_i,
   input  logic              wr_single_i,
   input  logic              stop_i,
   input  logic [RSVD_W-1:0] rsvd_bits_i,
   output logic [COL_W-1:0]  col_o,
   output logic              valid_o,
   output logic              last_o,
   output logic              mode_bad_o
);

   if (COL_W < 3) begin : g_bad_col_w
      $error("sdram_burst_colgen: COL_W must cover an 8-beat burst");
   end
   if (RSVD_W < 1) begin : g_bad_rsvd_w
      $error("sdram_burst_colgen: RSVD_W must be at least 1");
   end

   logic [COL_W-1:0] dec_mask;
   logic             dec_legal;
   logic             dec_page;
   logic             load_w;
   logic             use_xor;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] cnt_q;
   logic [COL_W-1:0] cfg_mask;
   logic             xor_q;

   colgen_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i      (len_code_i),
      .force_one_i (is_write_i && wr_single_i),
      .mask_o      (dec_mask),
      .legal_o     (dec_legal),
      .page_o      (dec_page)
   );

   assign load_w  = start_i && dec_legal;
   assign use_xor = (beat_order_e'(order_i) == ORD_XOR) && !dec_page;

   colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_w),
      .stop_i  (stop_i),
      .col_i   (start_col_i),
      .mask_i  (dec_mask),
      .xor_i   (use_xor),
      .base_o  (base_q),
      .cnt_o   (cnt_q),
      .mask_o  (cfg_mask),
      .xor_o   (xor_q),
      .valid_o (valid_o),
      .final_o (last_o)
   );

   colgen_addr_map #(.COL_W(COL_W)) u_map (
      .base_i (base_q),
      .cnt_i  (cnt_q),
      .mask_i (cfg_mask),
      .xor_i  (xor_q),
      .col_o  (col_o)
   );

   assign mode_bad_o = |rsvd_bits_i;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [2:0]       len_code_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic [COL_W-1:0] cfg_mask
);

   logic code_ok;
   logic go;
   assign code_ok = !len_code_i[2] || (len_code_i == 3'b111);
   assign go      = start_i && code_ok;

   p_start_col_r1: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (valid_o && col_o == $past(start_col_i)));

   p_reserved_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && start_i && !code_ok) |=> !valid_o);

   p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !stop_i && !go)
         |=> (valid_o && ((col_o & ~cfg_mask) == $past(col_o & ~cfg_mask))));

   p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !go) |=> !valid_o);

   p_last_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   p_last_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !go) |=> !valid_o);

endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .len_code_i  (len_code_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o),
   .cfg_mask    (cfg_mask)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

   localparam int COL_W  = 8;
   localparam int RSVD_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [COL_W-1:0]  start_col_i = '0;
   logic              is_write_i = 1'b0;
   logic [2:0]        len_code_i = 3'b000;
   logic              order_i = 1'b0;
   logic              wr_single_i = 1'b0;
   logic              stop_i = 1'b0;
   logic [RSVD_W-1:0] rsvd_bits_i = '0;
   logic [COL_W-1:0]  col_o;
   logic              valid_o;
   logic              last_o;
   logic              mode_bad_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sdram_burst_colgen #(.COL_W(COL_W), .RSVD_W(RSVD_W)) dut (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_col(input int base, input int n, input int len, input bit il);
      int m = len - 1;
      if (il) return (base & ~m & 255) | ((base ^ n) & m);
      return (base & ~m & 255) | ((base + n) & m);
   endfunction

   task automatic drive_start(input int col, input logic [2:0] code, input bit ord,
                              input bit wr, input bit single, input bit stp);
      start_i = 1'b1; start_col_i = COL_W'(col); len_code_i = code;
      order_i = ord; is_write_i = wr; wr_single_i = single; stop_i = stp;
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
   endtask

   // Walks beats 0..len-1 (first beat already on the outputs), then checks the drop.
   task automatic walk(input string req, input int col, input int len, input bit il);
      for (int n = 0; n < len; n++) begin
         check(valid_o === 1'b1, req, int'(valid_o), 1);
         check(int'(col_o) == exp_col(col, n, len, il), req, int'(col_o), exp_col(col, n, len, il));
         check(last_o === (n == len - 1), {req, " last"}, int'(last_o), int'(n == len - 1));
         @(negedge clk);
      end
      check(valid_o === 1'b0, {req, " R10 drop"}, int'(valid_o), 0);
   endtask

   task automatic t_reset();
      check(valid_o === 1'b0, "R10 reset valid", int'(valid_o), 0);
      check(last_o === 1'b0, "R10 reset last", int'(last_o), 0);
   endtask

   task automatic t_lengths();
      drive_start(8'h35, 3'b000, 0, 0, 0, 0); walk("R2 BL1", 8'h35, 1, 0);
      drive_start(8'h35, 3'b001, 0, 0, 0, 0); walk("R2 BL2", 8'h35, 2, 0);
      drive_start(8'h36, 3'b010, 0, 0, 0, 0); walk("R4 seq BL4", 8'h36, 4, 0);
      drive_start(8'h2D, 3'b011, 0, 0, 0, 0); walk("R4 seq BL8", 8'h2D, 8, 0);
   endtask

   task automatic t_interleave();
      drive_start(8'h4B, 3'b011, 1, 0, 0, 0); walk("R5 xor BL8", 8'h4B, 8, 1);
      drive_start(8'h92, 3'b010, 1, 0, 0, 0); walk("R5 xor BL4", 8'h92, 4, 1);
   endtask

   task automatic t_full_page();
      drive_start(8'hFD, 3'b111, 1, 0, 0, 0);
      walk("R6 page", 8'hFD, 256, 0);
   endtask

   task automatic t_write_single();
      drive_start(8'h77, 3'b011, 0, 1, 1, 0); walk("R7 wr single", 8'h77, 1, 0);
      drive_start(8'h77, 3'b011, 0, 1, 0, 0); walk("R7 wr burst", 8'h77, 8, 0);
      drive_start(8'h70, 3'b010, 0, 0, 1, 0); walk("R7 read ignores", 8'h70, 4, 0);
   endtask

   task automatic t_reserved();
      drive_start(8'h12, 3'b101, 0, 0, 0, 0);
      check(valid_o === 1'b0, "R3 idle reserved", int'(valid_o), 0);
      drive_start(8'h20, 3'b011, 0, 0, 0, 0);
      @(negedge clk);
      // beat 1 on outputs; a reserved start here must not disturb the burst
      drive_start(8'h99, 3'b110, 0, 0, 0, 0);
      check(int'(col_o) == 8'h22, "R3 running reserved", int'(col_o), 8'h22);
      check(valid_o === 1'b1, "R3 running valid", int'(valid_o), 1);
      repeat (6) @(negedge clk);
      check(valid_o === 1'b0, "R3 burst finished", int'(valid_o), 0);
   endtask

   task automatic t_stop();
      drive_start(8'h40, 3'b011, 0, 0, 0, 0);
      @(negedge clk); @(negedge clk);
      check(int'(col_o) == 8'h42, "R8 before stop", int'(col_o), 8'h42);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      check(valid_o === 1'b0, "R8 stopped", int'(valid_o), 0);
      @(negedge clk);
      check(valid_o === 1'b0, "R8 stays idle", int'(valid_o), 0);
   endtask

   task automatic t_restart_with_stop();
      drive_start(8'h10, 3'b011, 0, 0, 0, 0);
      @(negedge clk); @(negedge clk);
      drive_start(8'h45, 3'b010, 0, 0, 0, 1);
      walk("R9 start beats stop", 8'h45, 4, 0);
   endtask

   task automatic t_last_then_start();
      drive_start(8'h08, 3'b001, 0, 0, 0, 0);
      @(negedge clk);
      check(last_o === 1'b1, "R10 last shown", int'(last_o), 1);
      drive_start(8'hC3, 3'b010, 1, 0, 0, 0);
      walk("R9 back to back", 8'hC3, 4, 1);
   endtask

   task automatic t_mode_bad();
      check(mode_bad_o === 1'b0, "R11 clean", int'(mode_bad_o), 0);
      for (int b = 0; b < RSVD_W; b++) begin
         rsvd_bits_i = '0; rsvd_bits_i[b] = 1'b1; #1;
         check(mode_bad_o === 1'b1, "R11 bit set", int'(mode_bad_o), 1);
      end
      rsvd_bits_i = '0; #1;
      check(mode_bad_o === 1'b0, "R11 cleared", int'(mode_bad_o), 0);
   endtask

   task automatic t_start_col();
      drive_start(8'hE6, 3'b011, 1, 0, 0, 0);
      check(int'(col_o) == 8'hE6, "R1 first beat", int'(col_o), 8'hE6);
      check(valid_o === 1'b1, "R1 valid", int'(valid_o), 1);
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_start_col();
      t_lengths();
      t_interleave();
      t_full_page();
      t_write_single();
      t_reserved();
      t_stop();
      t_restart_with_stop();
      t_last_then_start();
      t_mode_bad();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule